// File: doc/BRIEF.md
# External Interrupt Sense Channel Bank

This block watches a set of asynchronous input pins and raises a sticky interrupt flag for each pin whose configured condition is met. Each pin first crosses into the system clock domain through a two-flop synchronizer. It is then sampled on a sample-clock enable, so the sample rate can be much slower than the system clock. An optional three-sample majority vote can be placed in front of the detector.

Each channel detects one of five conditions: a rising edge, a falling edge, either edge, a high level or a low level. It can also be switched off. A detection sets the channel's flag, and the flag stays set until software clears it with a write-one-to-clear mask. The flags, each gated by its own enable bit, are ORed into one interrupt line.

In edge mode a cleared flag waits for a fresh edge. In level mode it is set again as long as the pin still matches. Configuration is written one channel at a time through a simple write port.

Top module: `ext_irq_bank`

## Requirements
- R1: After reset every flag is 0, irq is 0 and every channel's sense setting is off.
- R2: Sense codes are 0 off, 1 rising, 2 falling, 3 both edges, 4 high level and 5 low level. Codes 6 and 7, like code 0, never set a flag.
- R3: In rising mode without the filter, a 0-to-1 pin change sets the flag within 4 sample periods.
- R4: In falling mode a 1-to-0 change sets the flag, and a 0-to-1 change does not.
- R5: In both-edge mode either kind of change sets the flag.
- R6: In high or low level mode the flag is set while the pin is at that level. Without the filter, the synchronized pin is used on every system cycle, and the flag is set within one sample period.
- R7: In edge mode a cleared flag stays clear while the pin rests at its post-edge level, and it is set again only by a new qualifying edge.
- R8: With the filter on, the detector sees the 2-of-3 majority of the last three samples (patterns 011, 101, 110 and 111 give 1). A pulse lasting one sample period is therefore ignored, while the same pulse is detected without the filter.
- R9: With the filter on, edge detection sets the flag within 6 sample periods and level detection within 4.
- R10: A clear with clr_we clears only the flags whose clr_mask bit is 1. A detection in the same cycle wins, so a level that still matches keeps its flag set.
- R11: irq is the OR over channels of the flag ANDed with that channel's interrupt-enable bit.
- R12: Writing a channel's configuration reloads its edge history at the next sample, so a changed sense or filter setting does not create a spurious edge.
- R13: The pin is sampled only when sample_en is 1. Edge and filtered detection make no progress while sample_en stays 0.
- R14: A set flag stays set until a clear that selects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle strobe marking each sample instant |
| pin_async | input | NUM_CH | Asynchronous external pins |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel selected by the configuration write |
| cfg_sense | input | 3 | Sense code written to the channel |
| cfg_filt | input | 1 | Filter enable written to the channel |
| cfg_ien | input | 1 | Interrupt enable written to the channel |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | NUM_CH | Write-one-to-clear mask for the flags |
| flags | output | NUM_CH | Sticky per-channel interrupt flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check four properties on every cycle:
- a flag is sticky unless a clear selects it;
- an edge-mode flag rises only right after a sample strobe;
- a channel that is switched off never raises its flag and clears when told;
- irq is never high without a flag.

Only the bench scenarios can show the conditions themselves: that each sense code reacts to the right pin transitions, that latency stays within its bound, that the majority vote rejects a one-period pulse and a one-period glitch, and that clearing behaves differently in edge and level mode. The same holds for the absence of spurious edges after a reconfiguration.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [2:0] {
        SNS_OFF  = 3'd0,
        SNS_RISE = 3'd1,
        SNS_FALL = 3'd2,
        SNS_BOTH = 3'd3,
        SNS_HIGH = 3'd4,
        SNS_LOW  = 3'd5,
        SNS_RSV6 = 3'd6,
        SNS_RSV7 = 3'd7
    } sense_e;

    typedef struct packed {
        logic [2:0] samp;    // samp[0] newest, samp[2] oldest
        logic       lvl;     // detector-visible level after the last sample
        logic       reload;  // history must be refreshed before edges count
        logic       flag;
    } chan_st_t;

    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/ext_irq_cfg.sv
module ext_irq_cfg #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [CH_W-1:0]        ch,
    input  logic [2:0]             sense_in,
    input  logic                   filt_in,
    input  logic                   ien_in,
    output logic [NUM_CH-1:0][2:0] sense_q,
    output logic [NUM_CH-1:0]      filt_q,
    output logic [NUM_CH-1:0]      ien_q,
    output logic [NUM_CH-1:0]      upd
);

    typedef struct packed {
        logic [NUM_CH-1:0][2:0] sense;
        logic [NUM_CH-1:0]      filt;
        logic [NUM_CH-1:0]      ien;
    } cfg_regs_t;

    cfg_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        upd    = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (we && (ch == CH_W'(i))) begin
                regs_d.sense[i] = sense_in;
                regs_d.filt[i]  = filt_in;
                regs_d.ien[i]   = ien_in;
                upd[i]          = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign sense_q = regs_q.sense;
    assign filt_q  = regs_q.filt;
    assign ien_q   = regs_q.ien;

endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_en,
    input  logic       pin_s,
    input  logic [2:0] sense,
    input  logic       filt,
    input  logic       upd,
    input  logic       clr,
    output logic       flag
);

    chan_st_t st_d, st_q;
    sense_e   mode;
    logic [2:0] win;
    logic       nv;
    logic       edge_ok;
    logic       rise_ev, fall_ev;
    logic       lvl_src;
    logic       det;

    always_comb begin
        mode    = sense_e'(sense);
        win     = {st_q.samp[1:0], pin_s};
        nv      = filt ? maj3(win) : pin_s;
        edge_ok = smp_en && !st_q.reload && !upd;
        rise_ev = edge_ok &&  nv && !st_q.lvl;
        fall_ev = edge_ok && !nv &&  st_q.lvl;
        lvl_src = filt ? st_q.lvl : pin_s;

        unique case (mode)
            SNS_RISE: det = rise_ev;
            SNS_FALL: det = fall_ev;
            SNS_BOTH: det = rise_ev | fall_ev;
            SNS_HIGH: det = lvl_src;
            SNS_LOW:  det = !lvl_src;
            default:  det = 1'b0;
        endcase

        st_d = st_q;
        if (smp_en) begin
            st_d.samp = win;
            st_d.lvl  = nv;
        end
        if (upd)         st_d.reload = 1'b1;
        else if (smp_en) st_d.reload = 1'b0;
        st_d.flag = (st_q.flag & ~clr) | det;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{samp: 3'b000, lvl: 1'b0, reload: 1'b1, flag: 1'b0};
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/ext_irq_bank.sv
module ext_irq_bank #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic [NUM_CH-1:0] pin_async,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [2:0]        cfg_sense,
    input  logic              cfg_filt,
    input  logic              cfg_ien,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_mask,
    output logic [NUM_CH-1:0] flags,
    output logic              irq
);

    logic [NUM_CH-1:0]      pin_s;
    logic [NUM_CH-1:0][2:0] cfg_sense_q;
    logic [NUM_CH-1:0]      cfg_filt_q;
    logic [NUM_CH-1:0]      cfg_ien_q;
    logic [NUM_CH-1:0]      cfg_upd;

    ext_irq_sync #(.W(NUM_CH), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_async),
        .dout (pin_s)
    );

    ext_irq_cfg #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .ch      (cfg_ch),
        .sense_in(cfg_sense),
        .filt_in (cfg_filt),
        .ien_in  (cfg_ien),
        .sense_q (cfg_sense_q),
        .filt_q  (cfg_filt_q),
        .ien_q   (cfg_ien_q),
        .upd     (cfg_upd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ext_irq_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .smp_en(sample_en),
            .pin_s (pin_s[g]),
            .sense (cfg_sense_q[g]),
            .filt  (cfg_filt_q[g]),
            .upd   (cfg_upd[g]),
            .clr   (clr_we & clr_mask[g]),
            .flag  (flags[g])
        );
    end

    assign irq = |(flags & cfg_ien_q);

endmodule

// File: rtl/ext_irq_bank_chk.sv
module ext_irq_bank_chk #(
    parameter int NUM_CH = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sample_en,
    input logic                   clr_we,
    input logic [NUM_CH-1:0]      clr_mask,
    input logic [NUM_CH-1:0]      flags,
    input logic                   irq,
    input logic [NUM_CH-1:0][2:0] sense_q
);

    // R11
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|flags));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        logic edge_mode, off_mode, hit;
        assign edge_mode = (sense_q[g] == 3'd1) || (sense_q[g] == 3'd2) || (sense_q[g] == 3'd3);
        assign off_mode  = (sense_q[g] == 3'd0) || (sense_q[g] == 3'd6) || (sense_q[g] == 3'd7);
        assign hit       = clr_we && clr_mask[g];

        // R14
        flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && !hit) |=> flags[g]);

        // R13
        edge_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_mode && !flags[g]) |=> (!flags[g] || $past(sample_en)));

        // R2
        off_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (off_mode && !flags[g]) |=> !flags[g]);

        // R10
        off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (off_mode && hit) |=> !flags[g]);
    end

endmodule

bind ext_irq_bank ext_irq_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_en(sample_en),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .flags    (flags),
    .irq      (irq),
    .sense_q  (cfg_sense_q)
);

// File: tb/ext_irq_bank_test.sv
`timescale 1ns/1ps
module ext_irq_bank_test;

    localparam int NCH = 4;
    localparam int SP  = 4;   // system cycles per sample period

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sample_en = 1'b0;
    logic [NCH-1:0] pin_async = '0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_ch = '0;
    logic [2:0]     cfg_sense = '0;
    logic           cfg_filt = 1'b0;
    logic           cfg_ien = 1'b0;
    logic           clr_we = 1'b0;
    logic [NCH-1:0] clr_mask = '0;
    logic [NCH-1:0] flags;
    logic           irq;

    int  checks = 0;
    int  errors = 0;
    bit  smp_run = 1'b1;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    ext_irq_bank #(.NUM_CH(NCH)) uut (.*);

    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            sample_en = smp_run && (cnt == 0);
            cnt = (cnt + 1) % SP;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_sp(input int n);
        repeat (n * SP) @(negedge clk);
    endtask

    task automatic cfg(input int ch, input int sense, input bit filt, input bit ien);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sense = 3'(sense); cfg_filt = filt; cfg_ien = ien;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear(input logic [NCH-1:0] m);
        @(negedge clk);
        clr_we = 1'b1; clr_mask = m;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = '0;
    endtask

    // returns cycles until flag seen, or 9999
    task automatic wait_flag(input int ch, input int max_sp, output int cyc);
        cyc = 9999;
        for (int i = 1; i <= max_sp * SP; i++) begin
            @(negedge clk);
            if (flags[ch]) begin cyc = i; break; end
        end
    endtask

    task automatic t_reset();
        chk("R1 flags after reset", int'(flags), 0);
        chk("R1 irq after reset", int'(irq), 0);
        pin_async = 4'b1111;
        wait_sp(3);
        chk("R1 sense off by default", int'(flags), 0);
        pin_async = '0;
        wait_sp(3);
    endtask

    task automatic t_rise();
        int c;
        cfg(0, 1, 1'b0, 1'b1);
        wait_sp(2);
        pin_async[0] = 1'b1;
        wait_flag(0, 4, c);
        chk("R3 rise latency within 4 periods", int'(c <= 4 * SP), 1);
        chk("R11 irq with enabled flag", int'(irq), 1);
        clear(4'b0001);
        wait_sp(3);
        chk("R7 no re-set at post-edge level", int'(flags[0]), 0);
        pin_async[0] = 1'b0;
        wait_sp(2);
        chk("R7 falling edge ignored in rise mode", int'(flags[0]), 0);
        pin_async[0] = 1'b1;
        wait_sp(3);
        chk("R7 new edge sets again", int'(flags[0]), 1);
        pin_async[0] = 1'b0;
        clear(4'b0001);
        wait_sp(2);
    endtask

    task automatic t_fall();
        cfg(1, 2, 1'b0, 1'b1);
        wait_sp(2);
        pin_async[1] = 1'b1;
        wait_sp(3);
        chk("R4 rising edge ignored in fall mode", int'(flags[1]), 0);
        pin_async[1] = 1'b0;
        wait_sp(3);
        chk("R4 falling edge sets flag", int'(flags[1]), 1);
        clear(4'b0010);
    endtask

    task automatic t_both();
        cfg(2, 3, 1'b0, 1'b1);
        wait_sp(2);
        pin_async[2] = 1'b1;
        wait_sp(3);
        chk("R5 rise in both mode", int'(flags[2]), 1);
        clear(4'b0100);
        wait_sp(1);
        chk("R5 cleared before fall", int'(flags[2]), 0);
        pin_async[2] = 1'b0;
        wait_sp(3);
        chk("R5 fall in both mode", int'(flags[2]), 1);
    endtask

    task automatic t_mask();
        // ch2 set from t_both; set ch0 too, clear only ch0
        pin_async[0] = 1'b1;
        wait_sp(3);
        clear(4'b0001);
        @(negedge clk);
        chk("R10 unmasked flag kept", int'(flags[2]), 1);
        chk("R10 masked flag cleared", int'(flags[0]), 0);
        clear(4'b0100);
        chk("R10 second channel cleared", int'(flags[2]), 0);
        pin_async[0] = 1'b0;
        wait_sp(2);
    endtask

    task automatic t_level();
        int c;
        cfg(3, 4, 1'b0, 1'b1);
        pin_async[3] = 1'b1;
        wait_flag(3, 1, c);
        chk("R6 high level within one period", int'(c <= SP), 1);
        clear(4'b1000);
        chk("R10 detection wins over clear", int'(flags[3]), 1);
        pin_async[3] = 1'b0;
        repeat (3) @(negedge clk);
        clear(4'b1000);
        chk("R6 clear works once level gone", int'(flags[3]), 0);
        cfg(3, 5, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        chk("R6 low level sets flag", int'(flags[3]), 1);
        cfg(3, 0, 1'b0, 1'b1);
        clear(4'b1000);
    endtask

    task automatic t_ien();
        cfg(1, 4, 1'b0, 1'b0);
        pin_async[1] = 1'b1;
        wait_sp(2);
        chk("R11 flag set with irq disabled", int'(flags[1]), 1);
        chk("R11 irq masked by enable", int'(irq), 0);
        cfg(1, 4, 1'b0, 1'b1);
        @(negedge clk);
        chk("R11 irq after enable", int'(irq), 1);
        pin_async[1] = 1'b0;
        cfg(1, 0, 1'b0, 1'b0);
        clear(4'b0010);
    endtask

    task automatic t_reserved();
        cfg(1, 6, 1'b0, 1'b1);
        cfg(2, 7, 1'b0, 1'b1);
        wait_sp(2);
        pin_async[2:1] = 2'b11;
        wait_sp(3);
        pin_async[2:1] = 2'b00;
        wait_sp(3);
        chk("R2 reserved codes never flag", int'(flags[2:1]), 0);
        chk("R2 no irq from reserved codes", int'(irq), 0);
    endtask

    task automatic t_filter();
        int c;
        cfg(0, 1, 1'b1, 1'b1);
        wait_sp(4);
        pin_async[0] = 1'b1;
        repeat (SP) @(negedge clk);
        pin_async[0] = 1'b0;
        wait_sp(5);
        chk("R8 one-period pulse rejected by filter", int'(flags[0]), 0);
        cfg(0, 1, 1'b0, 1'b1);
        wait_sp(2);
        pin_async[0] = 1'b1;
        repeat (SP) @(negedge clk);
        pin_async[0] = 1'b0;
        wait_sp(3);
        chk("R8 same pulse seen without filter", int'(flags[0]), 1);
        clear(4'b0001);
        cfg(0, 1, 1'b1, 1'b1);
        wait_sp(4);
        pin_async[0] = 1'b1;
        wait_flag(0, 6, c);
        chk("R9 filtered edge within 6 periods", int'(c <= 6 * SP), 1);
        chk("R8 majority passes a held level", int'(flags[0]), 1);
        // falling glitch: 1,0,1 votes stay high
        cfg(0, 2, 1'b1, 1'b1);
        wait_sp(4);
        clear(4'b0001);
        pin_async[0] = 1'b0;
        repeat (SP) @(negedge clk);
        pin_async[0] = 1'b1;
        wait_sp(5);
        chk("R8 one-period glitch rejected", int'(flags[0]), 0);
        pin_async[0] = 1'b0;
        wait_sp(4);
        // level with filter
        cfg(3, 4, 1'b1, 1'b1);
        wait_sp(4);
        clear(4'b1001);
        pin_async[3] = 1'b1;
        wait_flag(3, 4, c);
        chk("R9 filtered level within 4 periods", int'(c <= 4 * SP), 1);
        pin_async[3] = 1'b0;
        cfg(3, 0, 1'b0, 1'b0);
        cfg(0, 0, 1'b0, 1'b0);
        clear(4'b1111);
    endtask

    task automatic t_gate();
        cfg(0, 1, 1'b0, 1'b1);
        wait_sp(2);
        smp_run = 1'b0;
        pin_async[0] = 1'b1;
        repeat (24) @(negedge clk);
        chk("R13 no detection without sample_en", int'(flags[0]), 0);
        smp_run = 1'b1;
        wait_sp(3);
        chk("R13 detection after sampling resumes", int'(flags[0]), 1);
        pin_async[0] = 1'b0;
        cfg(0, 0, 1'b0, 1'b0);
        clear(4'b0001);
    endtask

    task automatic t_reload();
        cfg(2, 0, 1'b0, 1'b1);
        pin_async[2] = 1'b1;
        wait_sp(3);
        cfg(2, 1, 1'b0, 1'b1);
        wait_sp(4);
        chk("R12 sense change makes no edge", int'(flags[2]), 0);
        cfg(2, 1, 1'b1, 1'b1);
        wait_sp(5);
        chk("R12 filter change makes no edge", int'(flags[2]), 0);
        pin_async[2] = 1'b0;
        wait_sp(4);
        pin_async[2] = 1'b1;
        wait_sp(5);
        chk("R12 real edge still seen", int'(flags[2]), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_both();
        t_mask();
        t_level();
        t_ien();
        t_reserved();
        t_filter();
        t_gate();
        t_reload();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule